// File: doc/BRIEF.md
# Time-of-Day Clock Counter with Fractional Rate Trim

This block holds the local time of day for a network time-synchronisation engine. The time is a 32-bit unsigned count of seconds plus a 31-bit fraction of a second. One fraction unit is 2^-31 s, which is about 0.4657 ns. Software programs the block through a small write-only register port. The self-clearing control bits can be read back on a dedicated output.

The block has two ways of running. In coarse mode the fraction advances by a programmable step on every clock cycle. Software corrects the time by writing a signed offset, which the block adds to or subtracts from the running time. In fine mode a 32-bit phase accumulator adds a rate word on every cycle. Each carry out of that accumulator advances the fraction by the step, so software can trim the rate in very small amounts. Fine mode is corrected only by loading an absolute time and by changing the rate word.

When the fraction reaches or passes one second, the block carries into the seconds. An offset that borrows below zero takes one from the seconds. A one-cycle tick strobe marks every cycle in which the time advanced.

Top module: `tod_clock`

Register map (write address on `wr_addr`):

| Address | Content |
|---|---|
| 0 | control |
| 1 | step, bits 7:0 |
| 2 | rate word shadow, bits 31:0 |
| 3 | update seconds |
| 4 | update fraction: bits 30:0 magnitude, bit 31 negative sign |

The control bits are:

| Bit | Meaning |
|---|---|
| 0 | run |
| 1 | mode: 1 = fine, 0 = coarse |
| 2 | load absolute time |
| 3 | apply offset |
| 4 | take rate word |

Bits 2 to 4 clear themselves when they act. The output `time_now` is {seconds[31:0], 1'b0, fraction[30:0]}.

Each clock edge performs exactly one of four operations, named in the RTL as follows:
- **OP_IDLE**: hold the time.
- **OP_ADVANCE**: add the step to the fraction.
- **OP_LOAD**: load the absolute time.
- **OP_SHIFT**: apply the signed offset.

The operation is chosen in priority order:
1. If run is clear, the operation is OP_IDLE.
2. Otherwise, if the load bit is set, it is OP_LOAD.
3. Otherwise, if the offset bit is set in coarse mode, it is OP_SHIFT.
4. Otherwise it is OP_ADVANCE in coarse mode. In fine mode it is OP_ADVANCE when the accumulator carries and OP_IDLE when it does not.

## Requirements
- R1: After reset, `time_now` is 0, `tick` is 0 and `ctl_rd` is 0. The step, the active rate word and the accumulator are also 0.
- R2: While control bit 0 (run) is 0, the time does not change and `tick` stays 0. Any set load, offset or rate bits stay pending and read back as 1 on `ctl_rd`.
- R3: With run set, control bit 2 (load) makes the time exactly {update seconds, update fraction bits 30:0} on the next clock edge. The sign bit 31 is ignored. On that edge `tick` is 0, the accumulator is cleared and bit 2 clears.
- R4: In coarse mode (bit 1 = 0) with nothing pending, the fraction grows by the step on every cycle and `tick` is 1 on every cycle.
- R5: When the fraction plus the step reaches or passes 2^31, the fraction becomes the sum minus 2^31 and the seconds go up by 1, on the same edge.
- R6: In fine mode (bit 1 = 1), N cycles after a load the time has advanced by floor(N·A/2^32)·step units, where A is the active rate word. `tick` is 1 exactly once for each accumulator carry.
- R7: A write to the rate word at address 2 has no effect until control bit 4 is set. With run set, bit 4 reads 1 for one cycle, then clears as the new rate word takes effect.
- R8: In coarse mode, control bit 3 with sign bit 0 adds the update time to the current time, carrying from the fraction into the seconds. The bit then clears.
- R9: In coarse mode, control bit 3 with sign bit 1 subtracts the update time. A borrow below zero adds 2^31 to the fraction and takes one more from the seconds.
- R10: In fine mode, control bit 3 clears without changing the time.
- R11: With a step of 43 and a rate word of 0xB191D857 (nominal for a 72 MHz clock), 72000 cycles advance the time by 2^31/1000 units within one step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | system clock |
| rst_n | input | 1 | active-low asynchronous reset |
| wr_en | input | 1 | register write strobe |
| wr_addr | input | 3 | register address |
| wr_data | input | 32 | register write data |
| ctl_rd | output | 5 | control register readback |
| time_now | output | 64 | current time {seconds, 0, fraction} |
| tick | output | 1 | one-cycle strobe on each advance |

## Verification
The bench targets these corner cases and the failure each one would expose:

- **Fraction rollover.** A design that compared with "greater than" instead of "reaches or passes" at the one-second boundary would be off by one second at the threshold. One that forgot the seconds carry would show a fraction that wraps silently.
- **Signed offset.** The add case with a carry and the subtract case with a borrow are both driven. A borrow that is ignored or taken in the wrong direction leaves the seconds off by one or two.
- **Fine-mode accumulator.** This is checked against the exact carry count. A design that advanced on every cycle, or that loaded a new rate word without the take bit, gives a different count.
- **Self-clearing and run gating.** Pending bits must survive while run is clear and must clear after exactly one acting edge. A design that drops them early, or lets them stick, shows up on `ctl_rd`.

// File: rtl/tod_pkg.sv
package tod_pkg;
    localparam int SEC_W  = 32;
    localparam int FRAC_W = 31;
    localparam int ACC_W  = 32;
    localparam int STEP_W = 8;
    localparam int DATA_W = 32;
    localparam int ADDR_W = 3;
    localparam int CTL_W  = 5;

    localparam int CTL_RUN   = 0;
    localparam int CTL_FINE  = 1;
    localparam int CTL_LOAD  = 2;
    localparam int CTL_SHIFT = 3;
    localparam int CTL_TAKE  = 4;

    localparam logic [ADDR_W-1:0] A_CTL  = 3'd0;
    localparam logic [ADDR_W-1:0] A_STEP = 3'd1;
    localparam logic [ADDR_W-1:0] A_RATE = 3'd2;
    localparam logic [ADDR_W-1:0] A_USEC = 3'd3;
    localparam logic [ADDR_W-1:0] A_UFRC = 3'd4;

    typedef enum logic [1:0] {
        OP_IDLE,
        OP_ADVANCE,
        OP_LOAD,
        OP_SHIFT
    } op_e;
endpackage

// File: rtl/tod_regs.sv
module tod_regs
    import tod_pkg::*;
#(
    parameter int SW = SEC_W,
    parameter int IW = STEP_W,
    parameter int DW = DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DW-1:0]     wr_data,
    input  logic              clr_load,
    input  logic              clr_shift,
    input  logic              clr_take,
    output logic [CTL_W-1:0]  ctl,
    output logic [IW-1:0]     step,
    output logic [DW-1:0]     rate_shadow,
    output logic [SW-1:0]     upd_sec,
    output logic [DW-1:0]     upd_frac
);
    logic ctl_wr;
    assign ctl_wr = wr_en && (wr_addr == A_CTL);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl         <= '0;
            step        <= '0;
            rate_shadow <= '0;
            upd_sec     <= '0;
            upd_frac    <= '0;
        end else begin
            if (clr_load)  ctl[CTL_LOAD]  <= 1'b0;
            if (clr_shift) ctl[CTL_SHIFT] <= 1'b0;
            if (clr_take)  ctl[CTL_TAKE]  <= 1'b0;
            if (wr_en) begin
                unique case (wr_addr)
                    A_CTL:   ctl         <= wr_data[CTL_W-1:0];
                    A_STEP:  step        <= wr_data[IW-1:0];
                    A_RATE:  rate_shadow <= wr_data;
                    A_USEC:  upd_sec     <= wr_data[SW-1:0];
                    A_UFRC:  upd_frac    <= wr_data;
                    default: ;
                endcase
            end
        end
    end

    // R3 / R7: an acting pending bit is gone one cycle later unless rewritten
    assert_load_selfclear_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_load && !ctl_wr) |=> !ctl[CTL_LOAD]);
    assert_take_selfclear_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_take && !ctl_wr) |=> !ctl[CTL_TAKE]);
endmodule

// File: rtl/tod_phase_acc.sv
module tod_phase_acc
    import tod_pkg::*;
#(
    parameter int AW = ACC_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic          clear,
    input  logic          take,
    input  logic [AW-1:0] rate_new,
    output logic [AW-1:0] rate_q,
    output logic          carry
);
    logic [AW-1:0] acc_q;
    logic [AW:0]   sum;

    assign sum   = {1'b0, acc_q} + {1'b0, rate_q};
    assign carry = run && sum[AW];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_q  <= '0;
            rate_q <= '0;
        end else begin
            if (take)       rate_q <= rate_new;
            if (clear)      acc_q  <= '0;
            else if (run)   acc_q  <= sum[AW-1:0];
        end
    end

    // R7: the active rate word only moves on a take request
    assert_rate_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !take |=> $stable(rate_q));
endmodule

// File: rtl/tod_time_math.sv
module tod_time_math
    import tod_pkg::*;
#(
    parameter int SW = SEC_W,
    parameter int FW = FRAC_W,
    parameter int IW = STEP_W
) (
    input  op_e           op,
    input  logic [SW-1:0] sec,
    input  logic [FW-1:0] frac,
    input  logic [IW-1:0] step,
    input  logic [SW-1:0] u_sec,
    input  logic [FW-1:0] u_frac,
    input  logic          u_neg,
    output logic [SW-1:0] sec_n,
    output logic [FW-1:0] frac_n
);
    logic [FW:0] adv_sum;
    logic [FW:0] off_sum;
    logic [FW:0] off_dif;

    assign adv_sum = {1'b0, frac} + {{(FW+1-IW){1'b0}}, step};
    assign off_sum = {1'b0, frac} + {1'b0, u_frac};
    assign off_dif = {1'b0, frac} - {1'b0, u_frac};

    always_comb begin
        sec_n  = sec;
        frac_n = frac;
        unique case (op)
            OP_IDLE: ;
            OP_ADVANCE: begin
                frac_n = adv_sum[FW-1:0];
                sec_n  = sec + {{(SW-1){1'b0}}, adv_sum[FW]};
            end
            OP_LOAD: begin
                frac_n = u_frac;
                sec_n  = u_sec;
            end
            OP_SHIFT: begin
                if (u_neg) begin
                    frac_n = off_dif[FW-1:0];
                    sec_n  = sec - u_sec - {{(SW-1){1'b0}}, off_dif[FW]};
                end else begin
                    frac_n = off_sum[FW-1:0];
                    sec_n  = sec + u_sec + {{(SW-1){1'b0}}, off_sum[FW]};
                end
            end
        endcase
    end
endmodule

// File: rtl/tod_clock.sv
module tod_clock
    import tod_pkg::*;
#(
    parameter int SW = SEC_W,
    parameter int FW = FRAC_W,
    parameter int AW = ACC_W,
    parameter int IW = STEP_W,
    parameter int DW = DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DW-1:0]     wr_data,
    output logic [CTL_W-1:0]  ctl_rd,
    output logic [SW+FW:0]    time_now,
    output logic              tick
);
    logic [CTL_W-1:0] ctl;
    logic [IW-1:0]    step;
    logic [DW-1:0]    rate_shadow;
    logic [SW-1:0]    upd_sec;
    logic [DW-1:0]    upd_frac;
    logic [AW-1:0]    rate_q;
    logic             carry;
    logic             run, fine, do_load, do_shift, do_take;
    logic [SW-1:0]    sec_q, sec_n;
    logic [FW-1:0]    frac_q, frac_n;
    op_e              op;

    assign run      = ctl[CTL_RUN];
    assign fine     = ctl[CTL_FINE];
    assign do_load  = run && ctl[CTL_LOAD];
    assign do_shift = run && ctl[CTL_SHIFT];
    assign do_take  = run && ctl[CTL_TAKE];

    tod_regs #(.SW(SW), .IW(IW), .DW(DW)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .clr_load   (do_load),
        .clr_shift  (do_shift),
        .clr_take   (do_take),
        .ctl        (ctl),
        .step       (step),
        .rate_shadow(rate_shadow),
        .upd_sec    (upd_sec),
        .upd_frac   (upd_frac)
    );

    tod_phase_acc #(.AW(AW)) u_acc (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (run && fine && !do_load),
        .clear   (do_load),
        .take    (do_take),
        .rate_new(rate_shadow[AW-1:0]),
        .rate_q  (rate_q),
        .carry   (carry)
    );

    // operation select, in priority order
    always_comb begin
        if (!run)                  op = OP_IDLE;
        else if (do_load)          op = OP_LOAD;
        else if (do_shift && !fine) op = OP_SHIFT;
        else if (!fine || carry)   op = OP_ADVANCE;
        else                       op = OP_IDLE;
    end

    tod_time_math #(.SW(SW), .FW(FW), .IW(IW)) u_math (
        .op    (op),
        .sec   (sec_q),
        .frac  (frac_q),
        .step  (step),
        .u_sec (upd_sec),
        .u_frac(upd_frac[FW-1:0]),
        .u_neg (upd_frac[DW-1]),
        .sec_n (sec_n),
        .frac_n(frac_n)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sec_q  <= '0;
            frac_q <= '0;
            tick   <= 1'b0;
        end else begin
            sec_q  <= sec_n;
            frac_q <= frac_n;
            tick   <= (op == OP_ADVANCE);
        end
    end

    assign ctl_rd   = ctl;
    assign time_now = {sec_q, 1'b0, frac_q};

    // R2: a halted counter holds its time
    assert_halt_frozen_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> $stable(time_now));
    // R2: no strobe without the run bit
    assert_tick_needs_run_R2: assert property (@(posedge clk) disable iff (!rst_n)
        tick |-> $past(run));
    // R5: an advance moves the seconds by at most one
    assert_advance_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_ADVANCE) |=> (sec_q == $past(sec_q) || sec_q == $past(sec_q) + 1'b1));
    // R3: a load leaves no strobe behind
    assert_load_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
        do_load |=> !tick);
endmodule

// File: tb/tod_clock_tb.sv
module tod_clock_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [4:0]  ctl_rd;
    logic [63:0] time_now;
    logic        tick;
    int          checks = 0;
    int          errors = 0;
    bit          done = 1'b0;

    always #5 clk = ~clk;

    tod_clock u_dut (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .ctl_rd  (ctl_rd),
        .time_now(time_now),
        .tick    (tick)
    );

    function automatic logic [63:0] tv(input logic [31:0] s, input logic [30:0] f);
        return {s, 1'b0, f};
    endfunction

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic edges(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    // load {s,f} in the given mode; returns just after the loading edge
    task automatic load(input logic [31:0] s, input logic [31:0] f, input logic fine);
        wr(3, s);
        wr(4, f);
        wr(0, {27'd0, 1'b0, 1'b0, 1'b1, fine, 1'b1});
        edges(1);
    endtask

    task automatic t_reset;
        chk("R1 time", time_now, 64'd0);
        chk("R1 tick", {63'd0, tick}, 64'd0);
        chk("R1 ctl", {59'd0, ctl_rd}, 64'd0);
    endtask

    task automatic t_halt;
        wr(3, 32'd7);
        wr(0, 32'h4);
        edges(3);
        chk("R2 time held", time_now, 64'd0);
        chk("R2 load pending", {59'd0, ctl_rd}, 64'h4);
        chk("R2 no tick", {63'd0, tick}, 64'd0);
        wr(0, 32'h5);
        edges(1);
        chk("R3 load after run", time_now, tv(32'd7, 31'd0));
        chk("R3 load bit cleared", {59'd0, ctl_rd}, 64'h1);
        chk("R3 no tick on load", {63'd0, tick}, 64'd0);
    endtask

    task automatic t_coarse;
        wr(1, 32'd5);
        load(32'd1, 32'h8000_0010, 1'b0);
        chk("R3 sign ignored", time_now, tv(32'd1, 31'h10));
        edges(3);
        chk("R4 coarse step", time_now, tv(32'd1, 31'h1F));
        chk("R4 coarse tick", {63'd0, tick}, 64'd1);
    endtask

    task automatic t_rollover;
        wr(1, 32'd100);
        load(32'd5, 32'h7FFF_FFCE, 1'b0);
        edges(1);
        chk("R5 rollover", time_now, tv(32'd6, 31'd50));
        wr(1, 32'd50);
        load(32'd9, 32'h7FFF_FFCE, 1'b0);
        edges(1);
        chk("R5 exact boundary", time_now, tv(32'd10, 31'd0));
    endtask

    task automatic t_offsets;
        wr(1, 32'd0);
        load(32'd10, 32'h7FFF_FFF6, 1'b0);
        wr(3, 32'd1);
        wr(4, 32'd30);
        wr(0, 32'h9);
        edges(1);
        chk("R8 add with carry", time_now, tv(32'd12, 31'd20));
        chk("R8 bit cleared", {59'd0, ctl_rd}, 64'h1);
        load(32'd10, 32'd100, 1'b0);
        wr(3, 32'd3);
        wr(4, 32'h8000_00C8);
        wr(0, 32'h9);
        edges(1);
        chk("R9 subtract with borrow", time_now, tv(32'd6, 31'h7FFF_FF9C));
    endtask

    task automatic t_fine_offset;
        wr(1, 32'd0);
        load(32'd20, 32'd0, 1'b1);
        wr(3, 32'd1);
        wr(4, 32'd5);
        wr(0, 32'hB);
        edges(1);
        chk("R10 fine offset ignored", time_now, tv(32'd20, 31'd0));
        chk("R10 bit cleared", {59'd0, ctl_rd}, 64'h3);
    endtask

    task automatic t_rate;
        wr(1, 32'd1);
        wr(2, 32'h8000_0000);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 3'd0; wr_data = 32'h13;
        @(negedge clk);
        wr_en = 1'b0;
        chk("R7 take pending", {59'd0, ctl_rd}, 64'h13);
        edges(1);
        chk("R7 take cleared", {59'd0, ctl_rd}, 64'h3);
        load(32'd0, 32'd0, 1'b1);
        edges(10);
        chk("R7 half rate", time_now, tv(32'd0, 31'd5));
        wr(2, 32'hFFFF_FFFF);
        load(32'd0, 32'd0, 1'b1);
        edges(10);
        chk("R7 shadow no effect", time_now, tv(32'd0, 31'd5));
        wr(0, 32'h13);
        load(32'd0, 32'd0, 1'b1);
        edges(10);
        chk("R7 new rate used", time_now, tv(32'd0, 31'd9));
    endtask

    task automatic fine_run(input logic [31:0] rate, input logic [7:0] stp, input int n,
                            output logic [63:0] units, output int ticks);
        wr(1, {24'd0, stp});
        wr(2, rate);
        wr(0, 32'h13);
        load(32'd0, 32'd0, 1'b1);
        ticks = 0;
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            @(negedge clk);
            if (tick) ticks++;
        end
        units = {31'd0, time_now[63:32], 31'd0} + {33'd0, time_now[30:0]};
    endtask

    task automatic t_fine_count;
        logic [63:0] units;
        logic [63:0] carries;
        int ticks;
        fine_run(32'h9E37_79B9, 8'd7, 1000, units, ticks);
        carries = (64'd1000 * 64'h9E37_79B9) >> 32;
        chk("R6 fine advance", units, carries * 7);
        chk("R6 tick per carry", ticks, carries);
    endtask

    task automatic t_default_rate;
        logic [63:0] units;
        logic [63:0] diff;
        int ticks;
        fine_run(32'hB191_D857, 8'd43, 72000, units, ticks);
        diff = (units > 64'd2147484) ? units - 64'd2147484 : 64'd2147484 - units;
        chk("R11 1 ms within one step", {63'd0, diff <= 64'd43}, 64'd1);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset;
        t_halt;
        t_coarse;
        t_rollover;
        t_offsets;
        t_fine_offset;
        t_rate;
        t_fine_count;
        t_default_rate;
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule